// File: doc/BRIEF.md
# Multi-Queue Write Select and Full Flag

This block is the write-port control of a flow-control buffer that holds several independent queues. On each rising write-clock edge it can capture a new queue selection from a write address bus qualified by an address-enable strobe. The high bits of the address name a device and the low bits name a queue. A selection belongs to this instance only when its device field matches a strapped device ID. The block keeps a fill counter per queue. An accepted write raises the count of the selected queue, and a read-side pulse lowers the count of the queue that pulse names.

The full flag is active low. It reports the state of the queue selected last, and it changes on the cycle after the selecting edge. The flag also has a drive-enable output, so that up to eight instances can share one flag line and only the instance that owns the current selection drives it. While this instance does not own the selection, its flag is held high.

A mode pin is sampled while reset is held. It selects one of two almost-full/almost-empty offsets, and that value is presented until the next reset.

Top module: `mq_wr_select`

## Requirements
- R1: While reset is held and after it, every fill counter is zero, `full_oe_o` is low and `full_no` is high.
- R2: The address fields are queue = `wr_addr_i[4:0]` and device = `wr_addr_i[7:5]`. At an edge where `wr_aden_i` is high, the selection is captured, and from then on `full_oe_o` is high exactly when the device field equals `dev_id_i`. At an edge where `wr_aden_i` is low, `full_oe_o` keeps its value.
- R3: After a selecting edge that targets this device, `full_no` is low exactly when the fill count of the newly selected queue equals DEPTH (16 by default).
- R4: A write is accepted at an edge where `wr_en_ni` is low, this device owns the current selection and `full_no` is high. An accepted write adds one to the fill count of the selected queue.
- R5: A write attempted while `full_no` is low is ignored, and the count stays at DEPTH. The count never exceeds DEPTH.
- R6: A write attempted while the selection targets another device changes no counter of this device.
- R7: A pulse on `rd_dec_i` lowers the count of queue `rd_qid_i` by one. A pulse on a queue whose count is zero is ignored.
- R8: An accepted write and a read pulse on the same queue at the same edge leave that count unchanged.
- R9: `offset_o` is 128 if `dflt_hi_i` was high at the last clock edge of reset, and 8 if it was low. Changes on `dflt_hi_i` after reset have no effect.
- R10: A write at the same edge as a new selection goes to the queue that was selected before that edge.
- R11: The queue counters are independent. Each queue keeps its own level regardless of traffic to the other queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_id_i | input | 3 | Strapped device ID of this instance |
| dflt_hi_i | input | 1 | Offset select, sampled during reset |
| wr_addr_i | input | 8 | Device field and queue field of the selection |
| wr_aden_i | input | 1 | Address enable, captures `wr_addr_i` |
| wr_en_ni | input | 1 | Write enable, active low |
| rd_dec_i | input | 1 | Read-side decrement pulse |
| rd_qid_i | input | 5 | Queue lowered by `rd_dec_i` |
| full_no | output | 1 | Full flag of the selected queue, active low |
| full_oe_o | output | 1 | Drive enable for the shared flag line |
| offset_o | output | 8 | Latched almost-full/almost-empty offset |

## Verification
Every result is due one edge after its stimulus. A selection, an accepted write, an ignored write and a decrement each show on `full_no` and `full_oe_o` right after the edge that sampled them. The offset is fixed by the last edge of reset. The bench drives every input on the falling edge and samples the outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. Queue levels cannot be read directly, so the bench proves each count at the ports. It writes or drains a known number of times and checks that the flag turns exactly at DEPTH.

// File: rtl/mq_wr_pkg.sv
package mq_wr_pkg;
  localparam int unsigned MQ_NUM_Q   = 32;
  localparam int unsigned MQ_DEV_W   = 3;
  localparam int unsigned MQ_DEPTH   = 16;
  localparam int unsigned MQ_OFF_W   = 8;
  localparam int unsigned MQ_OFF_LO  = 8;
  localparam int unsigned MQ_OFF_HI  = 128;
endpackage

// File: rtl/mq_sel_reg.sv
module mq_sel_reg #(
  parameter int unsigned DEV_W = 3,
  parameter int unsigned QID_W = 5,
  localparam int unsigned ADDR_W = DEV_W + QID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aden_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DEV_W-1:0]  dev_id_i,
  output logic              own_o,
  output logic [QID_W-1:0]  qid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_o <= 1'b0;
      qid_o <= '0;
    end else if (aden_i) begin
      own_o <= (addr_i[ADDR_W-1:QID_W] == dev_id_i);
      qid_o <= addr_i[QID_W-1:0];
    end
  end
endmodule

// File: rtl/mq_fill_ctr.sv
module mq_fill_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic do_inc, do_dec;

  assign full_o = (cnt_o == CNT_W'(DEPTH));
  assign do_inc = inc_i && !full_o;
  assign do_dec = dec_i && (cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (do_inc && !do_dec) cnt_o <= cnt_o + 1'b1;
    else if (do_dec && !do_inc) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/mq_offset_latch.sv
module mq_offset_latch #(
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned OFF_LO = 8,
  parameter int unsigned OFF_HI = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dflt_hi_i,
  output logic [OFF_W-1:0] offset_o
);
  logic hi_q;

  // sampled only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) hi_q <= dflt_hi_i;
  end

  assign offset_o = hi_q ? OFF_W'(OFF_HI) : OFF_W'(OFF_LO);
endmodule

// File: rtl/mq_wr_select.sv
module mq_wr_select
  import mq_wr_pkg::*;
#(
  parameter int unsigned NUM_Q  = MQ_NUM_Q,
  parameter int unsigned DEV_W  = MQ_DEV_W,
  parameter int unsigned DEPTH  = MQ_DEPTH,
  parameter int unsigned OFF_W  = MQ_OFF_W,
  parameter int unsigned OFF_LO = MQ_OFF_LO,
  parameter int unsigned OFF_HI = MQ_OFF_HI,
  localparam int unsigned QID_W  = $clog2(NUM_Q),
  localparam int unsigned ADDR_W = DEV_W + QID_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_W-1:0]  dev_id_i,
  input  logic              dflt_hi_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_aden_i,
  input  logic              wr_en_ni,
  input  logic              rd_dec_i,
  input  logic [QID_W-1:0]  rd_qid_i,
  output logic              full_no,
  output logic              full_oe_o,
  output logic [OFF_W-1:0]  offset_o
);
  logic                   own_q;
  logic [QID_W-1:0]       sel_qid;
  logic [NUM_Q-1:0]       full_vec;
  logic [NUM_Q*CNT_W-1:0] cnt_all;
  logic                   full_sel;
  logic                   wr_acc;

  mq_sel_reg #(.DEV_W(DEV_W), .QID_W(QID_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .aden_i   (wr_aden_i),
    .addr_i   (wr_addr_i),
    .dev_id_i (dev_id_i),
    .own_o    (own_q),
    .qid_o    (sel_qid)
  );

  assign full_sel = full_vec[sel_qid];
  assign wr_acc   = !wr_en_ni && own_q && !full_sel;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic inc, dec;
    assign inc = wr_acc && (sel_qid == QID_W'(i));
    assign dec = rd_dec_i && (rd_qid_i == QID_W'(i));
    mq_fill_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc),
      .dec_i  (dec),
      .cnt_o  (cnt_all[i*CNT_W +: CNT_W]),
      .full_o (full_vec[i])
    );
  end

  mq_offset_latch #(.OFF_W(OFF_W), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI)) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dflt_hi_i (dflt_hi_i),
    .offset_o  (offset_o)
  );

  // idle level when another device owns the line
  assign full_no   = !(own_q && full_sel);
  assign full_oe_o = own_q;
endmodule

// File: rtl/mq_wr_sva.sv
module mq_wr_sva #(
  parameter int unsigned NUM_Q  = 32,
  parameter int unsigned DEV_W  = 3,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned QID_W  = $clog2(NUM_Q),
  localparam int unsigned ADDR_W = DEV_W + QID_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [DEV_W-1:0]       dev_id_i,
  input logic [ADDR_W-1:0]      wr_addr_i,
  input logic                   wr_aden_i,
  input logic                   wr_en_ni,
  input logic                   rd_dec_i,
  input logic                   full_no,
  input logic                   full_oe_o,
  input logic [OFF_W-1:0]       offset_o,
  input logic [NUM_Q*CNT_W-1:0] cnt_all
);
  assert_sel_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_aden_i |=> full_oe_o == ($past(wr_addr_i[ADDR_W-1:QID_W]) == $past(dev_id_i)));

  assert_sel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_aden_i |=> $stable(full_oe_o));

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_oe_o |-> full_no);

  assert_full_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_ni && full_oe_o && !full_no && !wr_aden_i && !rd_dec_i) |=> !full_no);

  assert_offset_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(offset_o));

  for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_all[i*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
  end
endmodule

bind mq_wr_select mq_wr_sva #(
  .NUM_Q(NUM_Q), .DEV_W(DEV_W), .DEPTH(DEPTH), .OFF_W(OFF_W)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dev_id_i  (dev_id_i),
  .wr_addr_i (wr_addr_i),
  .wr_aden_i (wr_aden_i),
  .wr_en_ni  (wr_en_ni),
  .rd_dec_i  (rd_dec_i),
  .full_no   (full_no),
  .full_oe_o (full_oe_o),
  .offset_o  (offset_o),
  .cnt_all   (cnt_all)
);

// File: tb/sim_mq_wr_select.sv
`timescale 1ns/1ps
module sim_mq_wr_select;
  localparam int DEPTH = 16;
  localparam int NQ    = 32;
  localparam logic [2:0] MY_DEV = 3'd5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dflt_hi_i = 1'b1;
  logic [7:0] wr_addr_i = '0;
  logic       wr_aden_i = 1'b0;
  logic       wr_en_ni = 1'b1;
  logic       rd_dec_i = 1'b0;
  logic [4:0] rd_qid_i = '0;
  logic       full_no, full_oe_o;
  logic [7:0] offset_o;

  int n_chk = 0, n_bad = 0;
  int lvl [NQ];

  always #5 clk_i = ~clk_i;

  mq_wr_select u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .dev_id_i(MY_DEV), .dflt_hi_i(dflt_hi_i),
    .wr_addr_i(wr_addr_i), .wr_aden_i(wr_aden_i), .wr_en_ni(wr_en_ni),
    .rd_dec_i(rd_dec_i), .rd_qid_i(rd_qid_i),
    .full_no(full_no), .full_oe_o(full_oe_o), .offset_o(offset_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic sel(input logic [2:0] d, input logic [4:0] q);
    wr_addr_i = {d, q}; wr_aden_i = 1'b1;
    cyc();
    wr_aden_i = 1'b0;
  endtask

  task automatic wr1();
    wr_en_ni = 1'b0;
    cyc();
    wr_en_ni = 1'b1;
  endtask

  task automatic dec1(input logic [4:0] q);
    rd_dec_i = 1'b1; rd_qid_i = q;
    cyc();
    rd_dec_i = 1'b0;
  endtask

  task automatic chk_flag(input string req, input int level);
    chk(full_no == (level != DEPTH), req, full_no, level != DEPTH);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NQ; i++) lvl[i] = 0;
    repeat (4) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk(full_oe_o == 1'b0, "R1 oe", full_oe_o, 0);
    chk(full_no == 1'b1, "R1 flag", full_no, 1);
    // R9 high offset, later pin change ignored
    chk(offset_o == 8'd128, "R9 hi", offset_o, 128);
    dflt_hi_i = 1'b0;
    cyc(); cyc();
    chk(offset_o == 8'd128, "R9 hold", offset_o, 128);

    // R2 ownership sweep over all device IDs, and hold without aden
    for (int d = 0; d < 8; d++) begin
      sel(3'(d), 5'd0);
      chk(full_oe_o == (d == MY_DEV), "R2 own", full_oe_o, d == MY_DEV);
      cyc();
      chk(full_oe_o == (d == MY_DEV), "R2 hold", full_oe_o, d == MY_DEV);
    end

    // R4 R11 fill each queue to q mod (DEPTH+1)
    for (int q = 0; q < NQ; q++) begin
      sel(MY_DEV, 5'(q));
      chk_flag("R3 empty", 0);
      for (int k = 0; k < q % (DEPTH + 1); k++) begin
        wr1();
        lvl[q]++;
        chk_flag("R4 write", lvl[q]);
      end
    end
    // R3 R11 reselect sweep
    for (int q = 0; q < NQ; q++) begin
      sel(MY_DEV, 5'(q));
      chk(full_oe_o == 1'b1, "R3 oe", full_oe_o, 1);
      chk_flag("R11 level", lvl[q]);
    end

    // R5 write to full queue 16 ignored
    sel(MY_DEV, 5'd16);
    chk_flag("R5 full", lvl[16]);
    wr1();
    chk_flag("R5 still", lvl[16]);
    dec1(5'd16); lvl[16]--;
    chk_flag("R5 one read", lvl[16]);
    wr1(); lvl[16]++;
    chk_flag("R5 refill", lvl[16]);

    // R6 foreign write changes nothing here (queue 15 at 15)
    sel(3'd2, 5'd15);
    chk(full_oe_o == 1'b0, "R6 oe", full_oe_o, 0);
    chk(full_no == 1'b1, "R6 idle", full_no, 1);
    wr1();
    sel(MY_DEV, 5'd15);
    chk_flag("R6 level", lvl[15]);
    wr1(); lvl[15]++;
    chk_flag("R6 fill", lvl[15]);

    // R7 decrement at zero ignored (queue 0)
    dec1(5'd0);
    sel(MY_DEV, 5'd0);
    for (int k = 0; k < DEPTH; k++) begin
      wr1(); lvl[0]++;
      chk_flag("R7 zero", lvl[0]);
    end

    // R8 write plus read on same queue (queue 14 at 14)
    sel(MY_DEV, 5'd14);
    for (int k = 0; k < 3; k++) begin
      wr_en_ni = 1'b0; rd_dec_i = 1'b1; rd_qid_i = 5'd14;
      cyc();
      wr_en_ni = 1'b1; rd_dec_i = 1'b0;
      chk_flag("R8 net", lvl[14]);
    end
    for (int k = 0; k < 2; k++) begin
      wr1(); lvl[14]++;
      chk_flag("R8 fill", lvl[14]);
    end

    // R10 write at selecting edge targets old queue
    sel(MY_DEV, 5'd3);
    wr_addr_i = {MY_DEV, 5'd4}; wr_aden_i = 1'b1; wr_en_ni = 1'b0;
    cyc();
    wr_aden_i = 1'b0; wr_en_ni = 1'b1;
    lvl[3]++;
    chk_flag("R10 new", lvl[4]);
    while (lvl[4] < DEPTH) begin
      wr1(); lvl[4]++;
      chk_flag("R10 q4", lvl[4]);
    end
    sel(MY_DEV, 5'd3);
    while (lvl[3] < DEPTH) begin
      wr1(); lvl[3]++;
      chk_flag("R10 q3", lvl[3]);
    end

    // R9 low offset after new reset; R1 counters cleared
    rst_ni = 1'b0; dflt_hi_i = 1'b0;
    repeat (3) cyc();
    chk(full_oe_o == 1'b0, "R1 oe in reset", full_oe_o, 0);
    rst_ni = 1'b1;
    cyc();
    chk(offset_o == 8'd8, "R9 lo", offset_o, 8);
    dflt_hi_i = 1'b1;
    cyc();
    chk(offset_o == 8'd8, "R9 lo hold", offset_o, 8);
    sel(MY_DEV, 5'd16);
    chk_flag("R1 cleared", 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule